// File: doc/BRIEF.md
# Serial Peripheral Port with Configurable Select Pin

This block is an 8-bit synchronous serial port that works either as the clock-generating side of a link or as the clock-following side. Software programs it through four byte-wide locations on a simple register bus: a main control byte, a second control byte carrying the clock divider and pin options, a data byte, and a status byte. All four serial pins (clock, two data lines and the select line) leave the block as value/enable pairs, so the pads outside decide nothing.

In the clock-generating role the select pin can act in four ways. It can be a select input that detects a bus conflict, a general-purpose input, a general-purpose output, or an output that goes low automatically for each byte. The block can shift either end of the byte first without changing the data byte's bit layout. It can share one data pin for both directions, and it can stop its serial clock while an external wait input is held. The serial clock idles low. Data changes on the falling edge and is sampled on the rising edge.

Register map (bus_addr): 0 = CTRL, 1 = CFG, 2 = DATA (write starts a transfer, read returns the last received byte), 3 = STAT (read only). CTRL bits: [0] enable, [1] master, [2] select-output enable, [3] LSB-first, [4] select direction, [5] select output level. CFG bits: [0] single-pin data, [1] single-pin drive, [2] stop in wait, [7:4] clock divider. STAT bits: [7] transfer done, [6] mode fault, [5] busy, [0] synchronised select pin level.

Top module: `spi_port`

## Requirements
- R1: After reset CTRL, CFG and DATA read 0x00, STAT reads 0x01 with the select pin high, and every pin output enable is 0.
- R2: In master mode with CTRL[3]=0, a DATA write sends the byte most significant bit first on mosi_o while sampling miso_i, and DATA then reads the received byte with the first bit in bit 7. Each serial clock phase lasts CFG[7:4]+1 clock cycles.
- R3: With CTRL[3]=1 the byte goes out least significant bit first and the first received bit lands in DATA bit 0. The register layout itself is unchanged.
- R4: STAT[7] sets when the eighth bit completes and clears when DATA is read.
- R5: In master mode with CTRL[4]=1 and CTRL[2]=1, ss_oe is 1. ss_o falls when the transfer starts, CFG[7:4]+1 cycles before the first rising clock edge, and is high again once the byte completes.
- R6: In master mode with CTRL[4]=1 and CTRL[2]=0, ss_oe is 1 and ss_o follows CTRL[5].
- R7: In master mode with CTRL[4]=0 and CTRL[2]=1, a low select pin causes no fault and its level reads in STAT[0].
- R8: In master mode with CTRL[4]=0 and CTRL[2]=0, a low select pin raises a mode fault. This sets STAT[6], clears CTRL[1], aborts the transfer and drops sck_oe, mosi_oe and ss_oe. STAT[6] clears only on a CTRL write that follows a STAT read made while it was set.
- R9: In slave mode ss_oe stays 0 whatever CTRL[4:2] hold. While ss_i is low the block shifts on the external clock, drives miso_o with miso_oe=1, and receives from mosi_i.
- R10: With CFG[0]=1 in master mode, only the mosi pin carries data and miso_oe is 0. With CFG[1]=1 the block drives mosi_o; with CFG[1]=0 it releases mosi and receives from mosi_i.
- R11: With CFG[2]=1 the serial clock holds its level while wait_i is 1 and resumes afterwards. With CFG[2]=0, wait_i has no effect on a transfer.
- R12: A DATA write while a master transfer is busy is ignored and does not alter the byte being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on DATA and STAT) |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| wait_i | input | 1 | Wait-mode request |
| sck_i | input | 1 | Serial clock pin input |
| sck_o | output | 1 | Serial clock pin output |
| sck_oe | output | 1 | Serial clock pin output enable |
| mosi_i | input | 1 | Master-out data pin input |
| mosi_o | output | 1 | Master-out data pin output |
| mosi_oe | output | 1 | Master-out data pin output enable |
| miso_i | input | 1 | Master-in data pin input |
| miso_o | output | 1 | Master-in data pin output |
| miso_oe | output | 1 | Master-in data pin output enable |
| ss_i | input | 1 | Select pin input |
| ss_o | output | 1 | Select pin output |
| ss_oe | output | 1 | Select pin output enable |

## Verification
A wrong shift register or bit counter shows within one byte as a mismatch between the bits sent on the data pin and the byte read from DATA. A wrong ordering flag shows in that same byte as a bit-reversed value. A bad divider or wait gate shows within a few clock phases, as a wrong count between the select falling and the first clock edge, or as a clock that moves while it should be frozen. A stuck fault or select state appears on the pin enables two or three cycles after the select pin moves, because the pin passes through a two-stage synchroniser.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DIV_W = 4,
  parameter int BITS  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [BITS-1:0]  bus_wdata,
  output logic [BITS-1:0]  bus_rdata,
  input  logic             wait_i,
  input  logic             sck_i,
  output logic             sck_o,
  output logic             sck_oe,
  input  logic             mosi_i,
  output logic             mosi_o,
  output logic             mosi_oe,
  input  logic             miso_i,
  output logic             miso_o,
  output logic             miso_oe,
  input  logic             ss_i,
  output logic             ss_o,
  output logic             ss_oe
);
  localparam int CW = $clog2(BITS);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic en, mstr, ssoe, lsbf, ss_dir, ss_gpo;
  logic bidir, bidir_oe, stop_wait;
  logic [DIV_W-1:0] baud, div;
  logic [BITS-1:0] sh, rdr;
  logic [CW-1:0] bcnt;
  logic rbit, busy, sck_q, done, modf, modf_arm, sck_d;
  logic [1:0] ss_y, sck_y, mosi_y, miso_y;

  wire ss_s    = ss_y[1];
  wire mst_act = en & mstr;
  wire sel     = en & ~mstr & ~ss_s;
  wire frozen  = stop_wait & wait_i;
  wire tick    = busy & ~frozen & (div == baud);
  wire m_rise  = tick & ~sck_q;
  wire m_fall  = tick & sck_q;
  wire s_rise  = sel & sck_y[1] & ~sck_d;
  wire s_fall  = sel & ~sck_y[1] & sck_d;
  wire rise    = m_rise | s_rise;
  wire fall    = m_fall | s_fall;
  wire din     = mstr ? (bidir ? mosi_i : miso_i) : (bidir ? miso_y[1] : mosi_y[1]);
  wire obit    = lsbf ? sh[0] : sh[BITS-1];
  wire [BITS-1:0] sh_nx = lsbf ? {rbit, sh[BITS-1:1]} : {sh[BITS-2:0], rbit};
  wire mfault  = mst_act & ~ss_dir & ~ssoe & ~ss_s;
  wire wr_ctl  = bus_wr & (bus_addr == 2'd0);
  wire wr_cfg  = bus_wr & (bus_addr == 2'd1);
  wire wr_dat  = bus_wr & (bus_addr == 2'd2);
  wire rd_dat  = bus_rd & (bus_addr == 2'd2);
  wire rd_sta  = bus_rd & (bus_addr == 2'd3);
  wire start   = wr_dat & ~busy & mst_act;

  assign sck_o   = sck_q;
  assign sck_oe  = mst_act;
  assign mosi_o  = mst_act ? obit : 1'b0;
  assign mosi_oe = mst_act & (~bidir | bidir_oe);
  assign miso_o  = obit;
  assign miso_oe = sel & (~bidir | bidir_oe);
  assign ss_oe   = mst_act & ss_dir;
  assign ss_o    = ssoe ? ~busy : ss_gpo;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = BITS'({ss_gpo, ss_dir, lsbf, ssoe, mstr, en});
      2'd1:    bus_rdata = BITS'({baud, 1'b0, stop_wait, bidir_oe, bidir});
      2'd2:    bus_rdata = rdr;
      default: bus_rdata = BITS'({done, modf, busy, 4'b0000, ss_s});
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en, mstr, ssoe, lsbf, ss_dir, ss_gpo} <= '0;
      {bidir, bidir_oe, stop_wait} <= '0;
      baud <= '0; div <= '0; sh <= '0; rdr <= '0; bcnt <= '0;
      rbit <= 1'b0; busy <= 1'b0; sck_q <= 1'b0; done <= 1'b0;
      modf <= 1'b0; modf_arm <= 1'b0; sck_d <= 1'b0;
      ss_y <= 2'b11; sck_y <= '0; mosi_y <= '0; miso_y <= '0;
    end else begin
      ss_y   <= {ss_y[0], ss_i};
      sck_y  <= {sck_y[0], sck_i};
      mosi_y <= {mosi_y[0], mosi_i};
      miso_y <= {miso_y[0], miso_i};
      sck_d  <= sck_y[1];
      if (wr_ctl) begin
        {ss_gpo, ss_dir, lsbf, ssoe, mstr, en} <= bus_wdata[5:0];
        if (modf_arm) begin
          modf <= 1'b0;
          modf_arm <= 1'b0;
        end
      end
      if (wr_cfg) begin
        baud      <= bus_wdata[7:4];
        stop_wait <= bus_wdata[2];
        bidir_oe  <= bus_wdata[1];
        bidir     <= bus_wdata[0];
      end
      if (rd_sta && modf) modf_arm <= 1'b1;
      if (rd_dat) done <= 1'b0;
      if (wr_dat && !busy) sh <= bus_wdata;
      if (!busy && !sel) bcnt <= '0;
      if (start) begin
        busy  <= 1'b1;
        div   <= '0;
        sck_q <= 1'b0;
        bcnt  <= '0;
      end else if (busy && !frozen) begin
        if (div == baud) begin
          div   <= '0;
          sck_q <= ~sck_q;
        end else begin
          div <= div + 1'b1;
        end
      end
      if (rise) rbit <= din;
      if (fall) begin
        sh   <= sh_nx;
        bcnt <= bcnt + 1'b1;
        if (bcnt == LAST) begin
          done <= 1'b1;
          rdr  <= sh_nx;
          busy <= 1'b0;
        end
      end
      if (busy && !mst_act) begin
        busy  <= 1'b0;
        sck_q <= 1'b0;
      end
      if (mfault) begin
        mstr     <= 1'b0;
        modf     <= 1'b1;
        modf_arm <= 1'b0;
        busy     <= 1'b0;
        sck_q    <= 1'b0;
      end
    end
  end

  a_r8_fault_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf) |-> (!sck_oe && !mosi_oe && !ss_oe && !busy));

  a_r4_done_after_eighth: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(fall && bcnt == LAST));

  a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck_q);

  a_r11_wait_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frozen && busy && mst_act && !mfault) |-> $stable(sck_q));

  a_r12_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(fall)) |-> $stable(sh));
endmodule

// File: tb/sim_spi_port.sv
module sim_spi_port;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic bus_wr = 0, bus_rd = 0, wait_i = 0, sck_i = 0, ss_i = 1;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic sck_o, sck_oe, mosi_i, mosi_o, mosi_oe, miso_i, miso_o, miso_oe, ss_o, ss_oe;
  logic s_mode = 0, s_mosi = 0;
  logic [7:0] m_tx = 0, m_rx = 0;
  int n_run = 0, n_fail = 0, cyc = 0;

  spi_port u0 (.clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
    .wait_i, .sck_i, .sck_o, .sck_oe, .mosi_i, .mosi_o, .mosi_oe, .miso_i, .miso_o,
    .miso_oe, .ss_i, .ss_o, .ss_oe);

  assign miso_i = m_tx[7];
  assign mosi_i = s_mode ? s_mosi : m_tx[7];
  always @(posedge sck_o) m_rx <= {m_rx[6:0], mosi_o};
  always @(negedge sck_o) m_tx <= {m_tx[6:0], 1'b0};

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wait_done();
    logic [7:0] s;
    s = 0;
    for (int i = 0; i < 2000 && !s[7]; i++) rd(2'd3, s);
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] slv, output logic [7:0] got);
    m_tx = slv; m_rx = 0;
    wr(2'd2, tx);
    wait_done();
    rd(2'd2, got);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(0, d); chk("R1 ctrl", d, 8'h00);
    rd(1, d); chk("R1 cfg", d, 8'h00);
    rd(2, d); chk("R1 data", d, 8'h00);
    rd(3, d); chk("R1 stat", d, 8'h01);
    chk("R1 oes", {sck_oe, mosi_oe, miso_oe, ss_oe}, 4'b0000);
  endtask

  task automatic t_msb();
    logic [7:0] d;
    wr(1, 8'h10); wr(0, 8'h17);
    xfer(8'h3C, 8'hA5, d);
    chk("R2 sent", m_rx, 8'h3C); chk("R2 rcvd", d, 8'hA5);
    rd(3, d); chk("R4 done cleared by data read", d[7], 1'b0);
    xfer(8'h81, 8'h7E, d);
    chk("R2 sent2", m_rx, 8'h81); chk("R2 rcvd2", d, 8'h7E);
  endtask

  task automatic t_lsb();
    logic [7:0] d;
    wr(0, 8'h1F);
    xfer(8'h01, 8'hC8, d);
    chk("R3 sent", m_rx, rev8(8'h01)); chk("R3 rcvd", d, rev8(8'hC8));
    rd(0, d); chk("R3 ctrl layout", d, 8'h1F);
  endtask

  task automatic t_done();
    logic [7:0] d;
    wr(0, 8'h17); m_tx = 8'h00;
    wr(2, 8'h55);
    wait_done();
    rd(3, d); chk("R4 done held", d[7], 1'b1);
    rd(2, d); rd(3, d); chk("R4 done cleared", d[7], 1'b0);
  endtask

  task automatic t_auto_ss();
    int n;
    wr(1, 8'h20); wr(0, 8'h17);
    chk("R5 idle high", {ss_oe, ss_o}, 2'b11);
    m_tx = 8'h00;
    wr(2, 8'hF0);
    chk("R5 low at start", ss_o, 1'b0);
    n = 0;
    while (!sck_o && n < 50) begin @(negedge clk); n++; end
    chk("R5 lead half period", n, 3);
    wait_done();
    chk("R5 high after byte", ss_o, 1'b1);
    wr(1, 8'h10);
  endtask

  task automatic t_gpo();
    wr(0, 8'h13); chk("R6 gpo low", {ss_oe, ss_o}, 2'b10);
    wr(0, 8'h33); chk("R6 gpo high", {ss_oe, ss_o}, 2'b11);
  endtask

  task automatic t_gpi();
    logic [7:0] d;
    wr(0, 8'h07); ss_i = 0; repeat (5) @(negedge clk);
    rd(3, d); chk("R7 no fault, level low", {d[6], d[0]}, 2'b00);
    rd(0, d); chk("R7 master kept", d[1], 1'b1);
    ss_i = 1; repeat (5) @(negedge clk);
    rd(3, d); chk("R7 level high", d[0], 1'b1);
  endtask

  task automatic t_modf();
    logic [7:0] d;
    wr(0, 8'h03); m_tx = 0; wr(2, 8'h99);
    repeat (3) @(negedge clk); ss_i = 0; repeat (5) @(negedge clk);
    chk("R8 enables dropped", {sck_oe, mosi_oe, ss_oe}, 3'b000);
    rd(0, d); chk("R8 master cleared", d, 8'h01);
    ss_i = 1; repeat (5) @(negedge clk);
    wr(0, 8'h03);
    rd(3, d); chk("R8 sticky flag", {d[6], d[5]}, 2'b10);
    wr(0, 8'h03);
    rd(3, d); chk("R8 flag cleared", d[6], 1'b0);
  endtask

  task automatic t_slave();
    logic [7:0] got, d;
    logic [7:0] ext;
    ext = 8'h5A; got = 0; s_mode = 1;
    wr(0, 8'h15); chk("R9 no ss drive", ss_oe, 1'b0);
    wr(2, 8'hA5);
    ss_i = 0; repeat (6) @(negedge clk);
    chk("R9 miso driven", miso_oe, 1'b1);
    for (int i = 0; i < 8; i++) begin
      s_mosi = ext[7-i];
      repeat (8) @(negedge clk);
      got[7-i] = miso_o;
      sck_i = 1; repeat (8) @(negedge clk); sck_i = 0;
    end
    repeat (8) @(negedge clk); ss_i = 1; repeat (4) @(negedge clk);
    chk("R9 miso released", miso_oe, 1'b0);
    chk("R9 slave sent", got, 8'hA5);
    rd(3, d); chk("R9 done", d[7], 1'b1);
    rd(2, d); chk("R9 slave rcvd", d, 8'h5A);
    s_mode = 0;
  endtask

  task automatic t_bidir();
    logic [7:0] d;
    wr(0, 8'h17); wr(1, 8'h13);
    xfer(8'hB2, 8'h00, d);
    chk("R10 drive enables", {mosi_oe, miso_oe}, 2'b10);
    chk("R10 shared pin sent", m_rx, 8'hB2);
    wr(1, 8'h11);
    xfer(8'h00, 8'h96, d);
    chk("R10 released", {mosi_oe, miso_oe}, 2'b00);
    chk("R10 shared pin rcvd", d, 8'h96);
    wr(1, 8'h10);
  endtask

  task automatic t_wait();
    logic [7:0] d;
    logic s;
    wr(0, 8'h17); wr(1, 8'h14);
    m_tx = 8'h33; m_rx = 0;
    wr(2, 8'hC3);
    repeat (5) @(negedge clk); wait_i = 1; repeat (2) @(negedge clk);
    s = sck_o; repeat (40) @(negedge clk);
    chk("R11 clock held", sck_o, s);
    rd(3, d); chk("R11 still busy", {d[7], d[5]}, 2'b01);
    wait_i = 0; wait_done(); rd(2, d);
    chk("R11 resumed rcvd", d, 8'h33); chk("R11 resumed sent", m_rx, 8'hC3);
    wr(1, 8'h10); wait_i = 1;
    xfer(8'h5A, 8'h0F, d);
    chk("R11 no stop when bit clear", d, 8'h0F);
    wait_i = 0;
  endtask

  task automatic t_busywr();
    logic [7:0] d;
    wr(0, 8'h17); m_tx = 8'h44; m_rx = 0;
    wr(2, 8'h6B); repeat (4) @(negedge clk);
    wr(2, 8'hFF);
    wait_done(); rd(2, d);
    chk("R12 byte unchanged", m_rx, 8'h6B); chk("R12 rcvd", d, 8'h44);
  endtask

  initial begin
    repeat (3) @(negedge clk); rst_n = 1; repeat (2) @(negedge clk);
    t_reset(); t_msb(); t_lsb(); t_done(); t_auto_ss(); t_gpo(); t_gpi();
    t_modf(); t_slave(); t_bidir(); t_wait(); t_busywr();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule